// File: doc/BRIEF.md
# Serial Dual-DAC Write Sequencer

This block sits on the host side of a dual-channel, 12-bit, serial-input digital-to-analog converter. It takes one write request at a time through a valid/ready handshake. A request holds a 2-bit channel address and a code of `CODE_W` bits. The block turns the request into a serial frame on four pins: a serial clock, a data line, an active-low chip select and an active-low load strobe. When the load pulse has finished, it raises a one-cycle done flag.

The frame is 2 address bits followed by the code, MSB first. Data changes only while the serial clock is low, and the converter captures it on each rising edge. Every gap around the frame is set by a nanosecond parameter. The block converts each one to a whole number of system-clock cycles, rounded up, with a minimum of one. The gaps are:

- the select lead time before the first clock,
- each clock phase,
- the deselect tail after the last clock,
- the load setup,
- the load pulse width,
- the load hold.

The load strobe stays high for the whole transfer, so the converter outputs only change on the single load pulse that follows deselect.

Top module: `dacwr_ctrl`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the next cycle up to and including the done cycle.
- R2: Each write shifts the bits of `{req_addr, req_code}` MSB first. `dac_sdi` changes only while `dac_sclk` is low, stays stable through each high phase, and is 0 outside select and shift.
- R3: `dac_sclk` idles low. During a write it makes exactly 2+`CODE_W` rising edges. Each low phase and each high phase lasts ceil(`HALF_NS`/`CLK_PERIOD_NS`) cycles, and the first phase is low.
- R4: `dac_cs_n` falls on the cycle after acceptance. It stays low for ceil(`SEL_NS`/period) cycles before the first clock low phase. After the last high phase it stays low for a further ceil(`DESEL_NS`/period) cycles, then returns high.
- R5: `dac_ld_n` is high whenever `dac_cs_n` is low.
- R6: After `dac_cs_n` rises, `dac_ld_n` stays high for ceil(`LSETUP_NS`/period) cycles. It then goes low exactly once for ceil(`LLOW_NS`/period) cycles, then stays high for ceil(`LHOLD_NS`/period) cycles.
- R7: `done` is high for exactly one cycle, the cycle after the load hold ends, once per write.
- R8: After reset, the outputs are `dac_cs_n`=1, `dac_ld_n`=1, `dac_sclk`=0, `dac_sdi`=0, `done`=0 and `req_ready`=1.
- R9: The first two bits shifted are `req_addr[1]` then `req_addr[0]`. Value 0x selects both channels, 10 selects channel A and 11 selects channel B. The block shifts them unmodified.
- R10: While a write is in progress, `req_valid` and any change of `req_addr` or `req_code` have no effect on the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 2 | Channel address sent first |
| req_code | input | CODE_W | Code sent MSB first |
| dac_sclk | output | 1 | Serial clock, idles low |
| dac_sdi | output | 1 | Serial data |
| dac_cs_n | output | 1 | Active-low chip select |
| dac_ld_n | output | 1 | Active-low load strobe |
| done | output | 1 | One-cycle pulse after the load hold |

## Verification
A wrong state or a timer fault in this block shows at the pins right away. One cycle too many or too few in any phase moves every later edge of `dac_cs_n`, `dac_sclk` or `dac_ld_n`. A bench that predicts each pin cycle by cycle sees the shift on the first cycle where it happens. A fault in the shift register or half-period counter shows as a wrong `dac_sdi` value under a high clock phase or a wrong count of rising edges. Decoding the captured frame places the fault in the address or the code field. Faults in the ready or done logic show within one cycle of acceptance or of the load hold.

// File: rtl/dacwr_pkg.sv
// Package: shared state encoding and ns-to-cycle conversion for the
// serial DAC write sequencer. Assumes positive integer times.
package dacwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SHIFT,
        ST_DESEL,
        ST_LSETUP,
        ST_LLOW,
        ST_LHOLD,
        ST_DONE
    } dacwr_state_e;

    // Round a minimum time up to whole system-clock cycles, at least one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dacwr_timer.sv
// Module: loadable down-counter that times each phase of the sequencer.
// A load of N-1 makes "expired" rise after N cycles in the phase.
// Assumes load_val fits in W bits.
module dacwr_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    // Count down to zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (load)           cnt <= load_val;
        else if (cnt != '0)      cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // Counter must never be reloaded from an all-ones value wrap (R3 timing).
    p_tmr_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(load) && $past(cnt) == '0) |-> cnt == '0);
endmodule

// File: rtl/dacwr_shifter.sv
// Module: frame register that presents its MSB on the serial line.
// It captures a frame on load and moves the next bit to the top on shift.
// Assumes load and shift are never requested together.
module dacwr_shifter #(
    parameter int FRAME_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic               shift,
    output logic               msb
);
    logic [FRAME_W-1:0] sr;

    // Capture a new frame or advance by one bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      sr <= '0;
        else if (load)   sr <= frame_in;
        else if (shift)  sr <= {sr[FRAME_W-2:0], 1'b0};
    end

    assign msb = sr[FRAME_W-1];

    // Controller never asks to load and shift in one cycle (R2).
    p_no_load_and_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift));
endmodule

// File: rtl/dacwr_fsm.sv
// Module: phase sequencer for one serial DAC write. It walks through
// select, shift (HALVES half-periods), deselect, load setup, load low,
// load hold and done, using an external phase timer. Assumes each
// cycle count is at least 1 and fits in TW bits.
module dacwr_fsm
    import dacwr_pkg::*;
#(
    parameter int TW      = 2,
    parameter int HALVES  = 28,
    parameter int SEL_C   = 2,
    parameter int HALF_C  = 2,
    parameter int DESEL_C = 1,
    parameter int LSET_C  = 1,
    parameter int LLOW_C  = 1,
    parameter int LHOLD_C = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          tmr_exp,
    output logic          req_ready,
    output logic          load_frame,
    output logic          shift,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          sdi_en,
    output logic          sclk,
    output logic          cs_n,
    output logic          ld_n,
    output logic          done
);
    localparam int HW = $clog2(HALVES);
    localparam logic [HW-1:0] LAST_HALF = HW'(HALVES - 1);

    dacwr_state_e state, state_nx;
    logic [HW-1:0] hcnt, hcnt_nx;

    // Next-state, timer reload and shift decisions.
    always_comb begin
        state_nx   = state;
        hcnt_nx    = hcnt;
        load_frame = 1'b0;
        shift      = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                state_nx   = ST_SELECT;
                load_frame = 1'b1;
                tmr_load   = 1'b1;
                tmr_val    = TW'(SEL_C - 1);
            end
            ST_SELECT: if (tmr_exp) begin
                state_nx = ST_SHIFT;
                hcnt_nx  = '0;
                tmr_load = 1'b1;
                tmr_val  = TW'(HALF_C - 1);
            end
            ST_SHIFT: if (tmr_exp) begin
                tmr_load = 1'b1;
                if (hcnt == LAST_HALF) begin
                    state_nx = ST_DESEL;
                    tmr_val  = TW'(DESEL_C - 1);
                end else begin
                    hcnt_nx = hcnt + 1'b1;
                    tmr_val = TW'(HALF_C - 1);
                    shift   = hcnt[0];
                end
            end
            ST_DESEL: if (tmr_exp) begin
                state_nx = ST_LSETUP;
                tmr_load = 1'b1;
                tmr_val  = TW'(LSET_C - 1);
            end
            ST_LSETUP: if (tmr_exp) begin
                state_nx = ST_LLOW;
                tmr_load = 1'b1;
                tmr_val  = TW'(LLOW_C - 1);
            end
            ST_LLOW: if (tmr_exp) begin
                state_nx = ST_LHOLD;
                tmr_load = 1'b1;
                tmr_val  = TW'(LHOLD_C - 1);
            end
            ST_LHOLD: if (tmr_exp) state_nx = ST_DONE;
            default:               state_nx = ST_IDLE;
        endcase
    end

    // Hold the phase and half-period index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            hcnt  <= '0;
        end else begin
            state <= state_nx;
            hcnt  <= hcnt_nx;
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign sdi_en    = (state == ST_SELECT) || (state == ST_SHIFT);
    assign sclk      = (state == ST_SHIFT) && hcnt[0];
    assign cs_n      = !((state == ST_SELECT) || (state == ST_SHIFT) || (state == ST_DESEL));
    assign ld_n      = (state != ST_LLOW);
    assign done      = (state == ST_DONE);

    // Half-period index stays inside the frame (R3).
    p_half_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hcnt <= LAST_HALF);
endmodule

// File: rtl/dacwr_ctrl.sv
// Module: top of the serial DAC write sequencer. It takes {addr, code}
// through valid/ready and drives the serial clock, data, active-low
// select and active-low load with every gap derived from ns parameters.
// Assumes CLK_PERIOD_NS is the system clock period.
module dacwr_ctrl
    import dacwr_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int CODE_W        = 12,
    parameter int HALF_NS       = 30,
    parameter int SEL_NS        = 30,
    parameter int DESEL_NS      = 20,
    parameter int LSETUP_NS     = 15,
    parameter int LLOW_NS       = 20,
    parameter int LHOLD_NS      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_addr,
    input  logic [CODE_W-1:0] req_code,
    output logic              dac_sclk,
    output logic              dac_sdi,
    output logic              dac_cs_n,
    output logic              dac_ld_n,
    output logic              done
);
    localparam int FRAME_W = 2 + CODE_W;
    localparam int HALVES  = 2 * FRAME_W;
    localparam int SEL_C   = ns_to_cyc(SEL_NS, CLK_PERIOD_NS);
    localparam int HALF_C  = ns_to_cyc(HALF_NS, CLK_PERIOD_NS);
    localparam int DESEL_C = ns_to_cyc(DESEL_NS, CLK_PERIOD_NS);
    localparam int LSET_C  = ns_to_cyc(LSETUP_NS, CLK_PERIOD_NS);
    localparam int LLOW_C  = ns_to_cyc(LLOW_NS, CLK_PERIOD_NS);
    localparam int LHOLD_C = ns_to_cyc(LHOLD_NS, CLK_PERIOD_NS);
    localparam int MAX_C   = max2(max2(max2(SEL_C, HALF_C), max2(DESEL_C, LSET_C)),
                                  max2(LLOW_C, LHOLD_C));
    localparam int TW      = (MAX_C < 2) ? 1 : $clog2(MAX_C);

    logic          load_frame, shift, tmr_load, tmr_exp, sdi_en, msb;
    logic [TW-1:0] tmr_val;

    dacwr_fsm #(
        .TW(TW), .HALVES(HALVES), .SEL_C(SEL_C), .HALF_C(HALF_C),
        .DESEL_C(DESEL_C), .LSET_C(LSET_C), .LLOW_C(LLOW_C), .LHOLD_C(LHOLD_C)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .tmr_exp(tmr_exp),
        .req_ready(req_ready), .load_frame(load_frame), .shift(shift),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .sdi_en(sdi_en),
        .sclk(dac_sclk), .cs_n(dac_cs_n), .ld_n(dac_ld_n), .done(done)
    );

    dacwr_timer #(.W(TW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expired(tmr_exp)
    );

    dacwr_shifter #(.FRAME_W(FRAME_W)) u_sr (
        .clk(clk), .rst_n(rst_n), .load(load_frame),
        .frame_in({req_addr, req_code}), .shift(shift), .msb(msb)
    );

    assign dac_sdi = sdi_en & msb;

    // Load strobe never active while the device is selected (R5).
    p_ld_high_when_selected_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_cs_n |-> dac_ld_n);
    // Serial clock low whenever deselected (R3).
    p_sclk_low_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dac_cs_n |-> !dac_sclk);
    // Data holds through every high clock phase (R2).
    p_sdi_stable_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dac_sclk |-> $stable(dac_sdi));
    // Ready drops right after a request is taken (R1).
    p_ready_drops_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // Load pulse starts only after select has been high a cycle (R6).
    p_load_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dac_ld_n) |-> (dac_cs_n && $past(dac_cs_n)));
    // Done follows a completed, released load pulse (R7).
    p_done_after_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dac_cs_n && dac_ld_n && $past(dac_ld_n) && !req_ready));
endmodule

// File: tb/dacwr_ctrl_tb.sv
// Bench: behavioural pin-level model of the write sequence, compared
// against the design on every falling clock edge.
module dacwr_ctrl_tb_top;
    localparam int PER = 20;
    localparam int CW  = 12;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int C_SEL = cyc(30), C_HALF = cyc(30), C_DESEL = cyc(20);
    localparam int C_LSET = cyc(15), C_LLOW = cyc(20), C_LHOLD = cyc(10);
    // Vector order: {ready, done, ld_n, cs_n, sdi, sclk}
    localparam logic [5:0] V_IDLE = 6'b101100;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [1:0] req_addr = '0;
    logic [CW-1:0] req_code = '0;
    logic dac_sclk, dac_sdi, dac_cs_n, dac_ld_n, done;

    dacwr_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_code(req_code), .dac_sclk(dac_sclk),
        .dac_sdi(dac_sdi), .dac_cs_n(dac_cs_n), .dac_ld_n(dac_ld_n), .done(done)
    );

    always #(PER/2) clk = ~clk;

    int total = 0, bad = 0, cycles = 0;
    int nwrites = 0, rises = 0, lfalls = 0, dones = 0, nbits = 0;
    bit started = 0, finished = 0;
    logic prev_sclk = 0, prev_ld = 1;
    logic [13:0] bits;
    logic [5:0] q[$];
    logic [13:0] fq[$];

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic push_write(input logic [13:0] f);
        repeat (C_SEL) q.push_back({1'b0, 1'b0, 1'b1, 1'b0, f[13], 1'b0});
        for (int h = 0; h < 28; h++)
            repeat (C_HALF) q.push_back({1'b0, 1'b0, 1'b1, 1'b0, f[13 - h/2], h[0]});
        repeat (C_DESEL) q.push_back(6'b001000);
        repeat (C_LSET)  q.push_back(6'b001100);
        repeat (C_LLOW)  q.push_back(6'b000100);
        repeat (C_LHOLD) q.push_back(6'b001100);
        q.push_back(6'b011100);
    endtask

    // Per-cycle comparison against the model.
    always @(negedge clk) begin
        if (rst_n && started && !finished) begin
            logic [5:0] e;
            e = (q.size() != 0) ? q.pop_front() : V_IDLE;
            chk("R3 sclk", dac_sclk, e[0]);
            chk("R2 sdi", dac_sdi, e[1]);
            chk("R4 cs_n", dac_cs_n, e[2]);
            chk("R6 ld_n", dac_ld_n, e[3]);
            chk("R7 done", done, e[4]);
            chk("R1 ready", req_ready, e[5]);
            if (!dac_cs_n) chk("R5 ld_n while selected", dac_ld_n, 1);
            if (dac_sclk && !prev_sclk) begin
                rises++;
                bits = {bits[12:0], dac_sdi};
                nbits++;
                if (nbits == 14) begin
                    logic [13:0] f;
                    f = (fq.size() != 0) ? fq.pop_front() : 14'h0;
                    chk("R9 R10 address", bits[13:12], f[13:12]);
                    chk("R2 R10 code", bits[11:0], f[11:0]);
                    nbits = 0;
                end
            end
            if (!dac_ld_n && prev_ld) lfalls++;
            if (done) dones++;
            prev_sclk = dac_sclk;
            prev_ld   = dac_ld_n;
            if (e[5] && req_valid) begin
                push_write({req_addr, req_code});
                fq.push_back({req_addr, req_code});
                nwrites++;
            end
        end
    end

    task automatic send(input logic [1:0] a, input logic [CW-1:0] c,
                        input bit garbage, input bit keep);
        req_addr  = a;
        req_code  = c;
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        if (garbage) begin
            req_addr = ~a;
            req_code = ~c;
            repeat (20) @(posedge clk);
            #1;
        end
        if (!keep) req_valid = 1'b0;
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog R7 actual=%0d expected=%0d", dones, nwrites);
            summary();
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R8 reset sclk", dac_sclk, 0);
        chk("R8 reset sdi", dac_sdi, 0);
        chk("R8 reset cs_n", dac_cs_n, 1);
        chk("R8 reset ld_n", dac_ld_n, 1);
        chk("R8 reset done", done, 0);
        chk("R8 reset ready", req_ready, 1);
        started = 1;
        @(posedge clk); #1;
        send(2'b00, 12'hFFF, 0, 0);   // both channels, full scale
        repeat (3) @(posedge clk); #1;
        send(2'b10, 12'h000, 1, 0);   // channel A, busy-time input changes
        send(2'b11, 12'hA5C, 0, 1);   // channel B, back-to-back follows
        send(2'b01, 12'h800, 0, 1);   // both channels, midscale
        send(2'b10, 12'h001, 1, 0);
        repeat (120) @(posedge clk);
        @(negedge clk);
        finished = 1;
        chk("R3 rising edge count", rises, 14 * nwrites);
        chk("R6 load pulse count", lfalls, nwrites);
        chk("R7 done pulse count", dones, nwrites);
        chk("R10 writes taken", nwrites, 5);
        chk("R2 frames pending", fq.size(), 0);
        summary();
    end
endmodule